// File: doc/BRIEF.md
# Half-Duplex SPI Boot-Flash Master

This block is a memory-mapped SPI master meant for a serial NOR boot flash. Software reaches it through three 32-bit registers on a simple request/acknowledge bus: a configuration word, a control/status word and a data word. Each access to the data word starts one transfer of one to four bytes in a single direction. A write to the data word sends bytes on MOSI. A read of the data word collects bytes from MISO and returns them. The data word is the only place where a transfer starts.

Chip-select pins follow register bits directly, so software frames a flash command by lowering chip select, issuing as many data accesses as the command needs, and raising it again. The bus stalls a data read until the last bit has arrived. It also holds off a data write that reaches a busy engine, so software only has to poll the ready flag if it wants to. The serial clock uses SPI mode 0 and is the system clock divided by an even parameter.

Top module: `spi_flash_master`

## Requirements
- R1: Register offsets are 0x00 for configuration, 0x08 for control/status and 0x0C for data. Configuration bits 28 and 27 are writable and read back, and its other bits read 0. Any other offset is acknowledged and reads 0.
- R2: Control/status bit 27 is a read-only ready flag. It reads 1 while the engine is idle and 0 from the start of a transfer until its last bit has completed.
- R3: Control/status bits 29:28 give the byte count minus one (0 means 1 byte, 3 means 4 bytes). The count is latched when a transfer starts, so rewriting the field during a transfer does not change that transfer.
- R4: Control/status bit 31 drives pin cs0_n and bit 30 drives pin cs1_n, both directly. Bit 24 is a stored select bit (0 selects device 0). A chip-select pin changes only after a control/status write.
- R5: With configuration bit 27 set, a data write sends its bytes most significant bit first, starting with bits 31:24 and going down. A 1-byte write sends only bits 31:24.
- R6: With configuration bit 28 set, a data read puts the first received byte in bits 31:24 and the next ones below it. Byte lanes that were not received read 0.
- R7: When configuration bit 27 is clear, a write byte-swaps the word before sending. When bit 28 is clear, a read byte-swaps the assembled word before returning it. So a 1-byte transfer then uses bits 7:0.
- R8: The engine is half-duplex: MOSI stays low throughout a data read.
- R9: SPI mode 0 is used. SCLK idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and one SCLK period is DIV system clocks.
- R10: The acknowledge for a data read comes in the cycle after the last bit has completed, and carries the received word.
- R11: A data write that arrives while a transfer is running is held without acknowledge until that transfer ends. It then starts and is not lost.
- R12: After reset, the control/status word reads 0xC800_0000 (both chip selects high, length 0, ready 1), configuration reads 0, and SCLK and MOSI are low.
- R13: Every access gets exactly one acknowledge, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs0_n | output | 1 | Chip select 0, active low |
| spi_cs1_n | output | 1 | Chip select 1, active low |

## Verification
Two pairs of functions can fall in the same cycle. The first is a new data access arriving while the engine is finishing a transfer. The bench provokes it by issuing a second data write right after the first one is acknowledged. It then checks that the second acknowledge comes only once every bit of the first word has been clocked out, and that both words reach the slave model in order. The second is a control/status write landing in the middle of a transfer. The bench rewrites the length and chip select while four bytes are being sent. It then checks that the register reads back at once with ready low and that the transfer still sends all 32 bits.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [3:0] OFF_CFG  = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h8;
  localparam logic [3:0] OFF_DATA = 4'hC;

  localparam int unsigned CFG_RD_BIG  = 28;
  localparam int unsigned CFG_WR_BIG  = 27;
  localparam int unsigned CTL_CS0     = 31;
  localparam int unsigned CTL_CS1     = 30;
  localparam int unsigned CTL_LEN_HI  = 29;
  localparam int unsigned CTL_LEN_LO  = 28;
  localparam int unsigned CTL_READY   = 27;
  localparam int unsigned CTL_SEL     = 24;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/spi_flash_regs.sv
module spi_flash_regs
  import spi_flash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eng_busy,
  output logic              rd_big,
  output logic              wr_big,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic [1:0]        len_m1,
  output logic [WORD_W-1:0] cfg_word,
  output logic [WORD_W-1:0] ctrl_word
);
  logic       rd_big_q, rd_big_d;
  logic       wr_big_q, wr_big_d;
  logic       cs0_q, cs0_d;
  logic       cs1_q, cs1_d;
  logic [1:0] len_q, len_d;
  logic       sel_q, sel_d;

  always_comb begin
    rd_big_d = rd_big_q;
    wr_big_d = wr_big_q;
    cs0_d    = cs0_q;
    cs1_d    = cs1_q;
    len_d    = len_q;
    sel_d    = sel_q;
    if (wr_cfg) begin
      rd_big_d = wdata[CFG_RD_BIG];
      wr_big_d = wdata[CFG_WR_BIG];
    end
    if (wr_ctrl) begin
      cs0_d = wdata[CTL_CS0];
      cs1_d = wdata[CTL_CS1];
      len_d = wdata[CTL_LEN_HI:CTL_LEN_LO];
      sel_d = wdata[CTL_SEL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_big_q <= 1'b0;
      wr_big_q <= 1'b0;
      cs0_q    <= 1'b1;
      cs1_q    <= 1'b1;
      len_q    <= 2'd0;
      sel_q    <= 1'b0;
    end else begin
      rd_big_q <= rd_big_d;
      wr_big_q <= wr_big_d;
      cs0_q    <= cs0_d;
      cs1_q    <= cs1_d;
      len_q    <= len_d;
      sel_q    <= sel_d;
    end
  end

  always_comb begin
    cfg_word             = '0;
    cfg_word[CFG_RD_BIG] = rd_big_q;
    cfg_word[CFG_WR_BIG] = wr_big_q;
    ctrl_word                       = '0;
    ctrl_word[CTL_CS0]              = cs0_q;
    ctrl_word[CTL_CS1]              = cs1_q;
    ctrl_word[CTL_LEN_HI:CTL_LEN_LO] = len_q;
    ctrl_word[CTL_READY]            = ~eng_busy;
    ctrl_word[CTL_SEL]              = sel_q;
  end

  assign rd_big = rd_big_q;
  assign wr_big = wr_big_q;
  assign cs0_n  = cs0_q;
  assign cs1_n  = cs1_q;
  assign len_m1 = len_q;
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import spi_flash_pkg::*;
#(
  parameter int unsigned DIV = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [1:0]        start_len,
  input  logic [WORD_W-1:0] start_tx,
  input  logic              miso,
  output logic              busy,
  output logic              rd,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(HALF + 1);

  logic              busy_q, busy_d;
  logic              rd_q, rd_d;
  logic              sclk_q, sclk_d;
  logic [CW-1:0]     div_q, div_d;
  logic [4:0]        bit_q, bit_d;
  logic [1:0]        len_q, len_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              tick, last;

  assign tick = (div_q == CW'(HALF - 1));
  assign last = (bit_q == {len_q, 3'b111});

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    sclk_d = sclk_q;
    div_d  = div_q;
    bit_d  = bit_q;
    len_d  = len_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = start_rd;
      len_d  = start_len;
      tx_d   = start_tx;
      rx_d   = '0;
      bit_d  = '0;
      div_d  = '0;
      sclk_d = 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[WORD_W-2:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (last) begin
            busy_d = 1'b0;
          end else begin
            bit_d = bit_q + 5'd1;
            tx_d  = {tx_q[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      len_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      sclk_q <= sclk_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      len_q  <= len_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign rd      = rd_q;
  assign done    = busy_q & tick & sclk_q & last;
  assign rx_word = rx_q << {~len_q, 3'b000};
  assign sclk    = sclk_q;
  assign mosi    = busy_q & ~rd_q & tx_q[WORD_W-1];
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
  import spi_flash_pkg::*;
#(
  parameter int unsigned DIV    = 4,
  parameter int unsigned ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs0_n,
  output logic              spi_cs1_n
);
  logic              ack_q, ack_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              pend_q, pend_d;
  logic              wr_cfg, wr_ctrl;
  logic              eng_start, eng_start_rd;
  logic              eng_busy, eng_rd, eng_done;
  logic [WORD_W-1:0] eng_rx, tx_word, rx_result;
  logic              rd_big, wr_big;
  logic [1:0]        len_m1;
  logic [WORD_W-1:0] cfg_word, ctrl_word;
  logic [3:0]        off;

  assign off       = bus_addr[3:0];
  assign tx_word   = wr_big ? bus_wdata : swap_bytes(bus_wdata);
  assign rx_result = rd_big ? eng_rx : swap_bytes(eng_rx);

  spi_flash_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cfg    (wr_cfg),
    .wr_ctrl   (wr_ctrl),
    .wdata     (bus_wdata),
    .eng_busy  (eng_busy),
    .rd_big    (rd_big),
    .wr_big    (wr_big),
    .cs0_n     (spi_cs0_n),
    .cs1_n     (spi_cs1_n),
    .len_m1    (len_m1),
    .cfg_word  (cfg_word),
    .ctrl_word (ctrl_word)
  );

  spi_flash_engine #(.DIV(DIV)) i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .start_rd  (eng_start_rd),
    .start_len (len_m1),
    .start_tx  (tx_word),
    .miso      (spi_miso),
    .busy      (eng_busy),
    .rd        (eng_rd),
    .done      (eng_done),
    .rx_word   (eng_rx),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi)
  );

  always_comb begin
    ack_d        = 1'b0;
    rdata_d      = rdata_q;
    pend_d       = pend_q;
    wr_cfg       = 1'b0;
    wr_ctrl      = 1'b0;
    eng_start    = 1'b0;
    eng_start_rd = 1'b0;
    if (pend_q) begin
      if (eng_done) begin
        ack_d   = 1'b1;
        rdata_d = rx_result;
        pend_d  = 1'b0;
      end
    end else if (bus_req && !ack_q) begin
      case (off)
        OFF_CFG: begin
          ack_d   = 1'b1;
          rdata_d = cfg_word;
          wr_cfg  = bus_we;
        end
        OFF_CTRL: begin
          ack_d   = 1'b1;
          rdata_d = ctrl_word;
          wr_ctrl = bus_we;
        end
        OFF_DATA: begin
          if (!eng_busy) begin
            eng_start    = 1'b1;
            eng_start_rd = ~bus_we;
            if (bus_we) begin
              ack_d   = 1'b1;
              rdata_d = '0;
            end else begin
              pend_d = 1'b1;
            end
          end
        end
        default: begin
          ack_d   = 1'b1;
          rdata_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      pend_q  <= pend_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/spi_flash_master_chk.sv
module spi_flash_master_chk #(
  parameter int unsigned ADDR_W = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              ack,
  input logic              sclk,
  input logic              mosi,
  input logic              cs0_n,
  input logic              cs1_n,
  input logic              busy,
  input logic              rd
);
  a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r9_sclk_moves_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(busy));

  a_r8_mosi_low_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd) |-> !mosi);

  a_r13_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r4_cs0_by_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs0_n) |-> $past(req && we && addr[3:0] == 4'h8));

  a_r4_cs1_by_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs1_n) |-> $past(req && we && addr[3:0] == 4'h8));

  a_r2_start_by_data_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && addr[3:0] == 4'hC));
endmodule

bind spi_flash_master spi_flash_master_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (bus_req),
  .we    (bus_we),
  .addr  (bus_addr),
  .ack   (bus_ack),
  .sclk  (spi_sclk),
  .mosi  (spi_mosi),
  .cs0_n (spi_cs0_n),
  .cs1_n (spi_cs1_n),
  .busy  (eng_busy),
  .rd    (eng_rd)
);

// File: tb/test_spi_flash_master.sv
`timescale 1ns/1ps
module test_spi_flash_master;
  localparam int unsigned DIV = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_req;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs0_n, spi_cs1_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  spi_flash_master #(.DIV(DIV), .ADDR_W(4)) i_spi_flash_master (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs0_n(spi_cs0_n), .spi_cs1_n(spi_cs1_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // slave model: captures MOSI on rising SCLK, presents MISO bits from slave_word
  logic [63:0] cap = '0;
  int          rise_cnt = 0;
  int          fall_cnt = 0;
  int          fall_base = 0;
  logic [31:0] slave_word = '0;
  longint      cyc = 0;
  longint      last_rise = 0;
  longint      rise_period = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge spi_sclk) begin
    cap         <= {cap[62:0], spi_mosi};
    rise_cnt    <= rise_cnt + 1;
    rise_period <= cyc - last_rise;
    last_rise   <= cyc;
  end
  always @(negedge spi_sclk) fall_cnt <= fall_cnt + 1;
  assign spi_miso = slave_word[31 - ((fall_cnt - fall_base) & 31)];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_access(input logic we, input logic [3:0] a, input logic [31:0] d,
                            output logic [31:0] rd, output int rises_at_ack);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    forever begin
      @(negedge clk);
      if (bus_ack) break;
    end
    rd = bus_rdata;
    rises_at_ack = rise_cnt;
    bus_req = 1'b0;
    @(negedge clk);
    check("R13 ack drops after one cycle", {31'b0, bus_ack}, 32'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r; int n;
    bus_access(1'b1, a, d, r, n);
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] r);
    int n;
    bus_access(1'b0, a, 32'h0, r, n);
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    do rdreg(4'h8, r); while (r[27] == 1'b0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R12 sclk low", {31'b0, spi_sclk}, 32'd0);
    check("R12 mosi low", {31'b0, spi_mosi}, 32'd0);
    check("R12 cs pins high", {30'b0, spi_cs0_n, spi_cs1_n}, 32'd3);
    rdreg(4'h8, r); check("R12 ctrl reset word", r, 32'hC800_0000);
    rdreg(4'h0, r); check("R12 cfg reset word", r, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    wr(4'h0, 32'hFFFF_FFFF);
    rdreg(4'h0, r); check("R1 cfg readback", r, 32'h1800_0000);
    wr(4'h4, 32'h1234_5678);
    rdreg(4'h4, r); check("R1 unmapped reads 0", r, 32'h0);
    wr(4'h8, 32'h3100_0000);
    rdreg(4'h8, r); check("R3 ctrl fields readback", r, 32'h3900_0000);
    check("R4 cs0 low cs1 low", {30'b0, spi_cs0_n, spi_cs1_n}, 32'd0);
    wr(4'h8, 32'h4000_0000);
    check("R4 cs0 low cs1 high", {30'b0, spi_cs0_n, spi_cs1_n}, 32'd1);
  endtask

  task automatic t_write(input logic [31:0] cfg, input logic [1:0] len,
                         input logic [31:0] d, input logic [31:0] exp, input string tag);
    logic [31:0] r; int base; int nb;
    nb = (int'(len) + 1) * 8;
    wr(4'h0, cfg);
    wr(4'h8, {2'b01, len, 28'h0});
    base = rise_cnt;
    wr(4'hC, d);
    rdreg(4'h8, r); check("R2 ready low during transfer", {31'b0, r[27]}, 32'd0);
    wait_idle();
    check({tag, " bit count"}, rise_cnt - base, nb);
    check(tag, cap[31:0] & ((nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1)), exp);
    check("R9 sclk idles low", {31'b0, spi_sclk}, 32'd0);
  endtask

  task automatic t_read(input logic [31:0] cfg, input logic [1:0] len,
                        input logic [31:0] sw, input logic [31:0] exp, input string tag);
    logic [31:0] r; int base; int at_ack; int nb;
    nb = (int'(len) + 1) * 8;
    wr(4'h0, cfg);
    wr(4'h8, {2'b01, len, 28'h0});
    slave_word = sw;
    fall_base  = fall_cnt;
    base       = rise_cnt;
    bus_access(1'b0, 4'hC, 32'h0, r, at_ack);
    check(tag, r, exp);
    check("R10 read ack after last bit", at_ack - base, nb);
    check("R8 mosi low while reading", cap[31:0] & ((nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1)), 32'h0);
    rdreg(4'h8, r); check("R2 ready after read", {31'b0, r[27]}, 32'd1);
  endtask

  task automatic t_backtoback();
    logic [31:0] r; int base; int at_ack;
    wr(4'h0, 32'h1800_0000);
    wr(4'h8, 32'h7000_0000);
    base = rise_cnt;
    wr(4'hC, 32'hDEAD_BEEF);
    bus_access(1'b1, 4'hC, 32'h0BAD_F00D, r, at_ack);
    check("R11 held write acked after first word", at_ack - base, 32);
    wait_idle();
    check("R11 first word sent", cap[63:32], 32'hDEAD_BEEF);
    check("R11 second word sent", cap[31:0], 32'h0BAD_F00D);
    check("R9 sclk period", 32'(rise_period), DIV);
  endtask

  task automatic t_ctrl_midway();
    logic [31:0] r; int base;
    wr(4'h8, 32'h7000_0000);
    base = rise_cnt;
    wr(4'hC, 32'h8421_C3A5);
    wr(4'h8, 32'hC000_0000);
    rdreg(4'h8, r); check("R2 ctrl write during transfer", r, 32'hC000_0000);
    check("R4 cs0 released mid transfer", {31'b0, spi_cs0_n}, 32'd1);
    wait_idle();
    check("R3 latched length", rise_cnt - base, 32);
    check("R3 latched word", cap[31:0], 32'h8421_C3A5);
  endtask

  initial begin
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_write(32'h1800_0000, 2'd3, 32'hA1B2_C3D4, 32'hA1B2_C3D4, "R5 four-byte write");
    t_write(32'h1800_0000, 2'd0, 32'h5E12_3456, 32'h0000_005E, "R5 one-byte write");
    t_write(32'h1000_0000, 2'd3, 32'h1122_3344, 32'h4433_2211, "R7 swapped write");
    t_write(32'h1000_0000, 2'd0, 32'h1122_3344, 32'h0000_0044, "R7 swapped one-byte write");
    t_read(32'h1800_0000, 2'd3, 32'hCAFE_F00D, 32'hCAFE_F00D, "R6 four-byte read");
    t_read(32'h1800_0000, 2'd1, 32'hCAFE_F00D, 32'hCAFE_0000, "R6 two-byte read");
    t_read(32'h0800_0000, 2'd3, 32'hCAFE_F00D, 32'h0DF0_FECA, "R7 swapped read");
    t_read(32'h0800_0000, 2'd0, 32'hCAFE_F00D, 32'h0000_00CA, "R7 swapped one-byte read");
    t_backtoback();
    t_ctrl_midway();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule